// File: doc/BRIEF.md
# Nibble-Wide Page-Mode DRAM Controller

This block connects an on-chip requester to an external DRAM whose data bus is four bits wide. The requester moves 16-bit words. The controller turns each word into a single page-mode burst: it strobes one row address, then four column addresses, and it carries one nibble per column. The block drives a 9-bit multiplexed address bus and the active-low strobes for row, column, write and output enable. Each strobe phase lasts a whole number of system clocks, and parameters set those counts. An input selects one of two address geometries. The small geometry is a 64K x 4 part that holds 16K words. The large geometry is a 256K x 4 part that holds 64K words.

An interval timer raises a refresh request, and the controller serves it with row-only refresh cycles taken from a wrapping row counter. A refresh never breaks into a burst. Once the burst ends, the refresh wins over any new user request. The requester holds `req` until it sees a one-cycle `ack`. A read returns its word with a one-cycle `rd_valid` pulse.

The sequencer uses the states IDLE, ROW_DLY, CAS_LO, CAS_HI, PRECHG and REFRESH. The transitions are:

| Transition | From | To | Condition |
| --- | --- | --- | --- |
| refresh grant | IDLE | REFRESH | a refresh is pending |
| user grant | IDLE | ROW_DLY | a request is waiting and no refresh is pending |
| column start | ROW_DLY | CAS_LO | the row delay count has expired |
| next column | CAS_LO | CAS_HI | the column low count has expired and the nibble is not the last |
| burst end | CAS_LO | PRECHG | the column low count has expired and the nibble is the last |
| column resume | CAS_HI | CAS_LO | the column high count has expired |
| refresh end | REFRESH | PRECHG | the refresh low count has expired |
| precharge done | PRECHG | IDLE | the precharge count has expired |

Top module: `nib_dram_ctrl`

## Requirements
- R1: During and right after reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, and `dram_dq_oe`, `ack` and `rd_valid` are low.
- R2: Every user burst has one falling edge of `dram_ras_n` and exactly four falling edges of `dram_cas_n` while it stays low. The first column strobe falls exactly T_RCD clocks after the row strobe falls.
- R3: With `cfg_mbit`=1, the row address is `req_addr[15:7]` and the column for nibble n is `{req_addr[6:0], n[1:0]}`.
- R4: With `cfg_mbit`=0, the row is `{0, req_addr[13:6]}` and the column for nibble n is `{0, req_addr[5:0], n[1:0]}`. `dram_a[8]` stays low at all times, and `req_addr[15:14]` has no effect, so two addresses that differ only in those bits reach the same word.
- R5: Nibble n of a word is bits [4n+3:4n]. The nibbles go out in the order 0, 1, 2, 3, and the low two column bits equal n.
- R6: In a write burst, at every falling edge of the column strobe, `dram_we_n` is low, `dram_oe_n` is high and `dram_dq_oe` is high with the nibble on `dram_dq_o`.
- R7: In a read burst, `dram_oe_n` is low and `dram_we_n` is high while the column strobe is low, and `dram_dq_oe` stays low. The nibble on `dram_dq_i` is sampled in the last clock of each column low phase.
- R8: After the fourth nibble of a read, `rd_valid` pulses for one clock and `rd_data` holds the assembled word.
- R9: `ack` is high for one clock per request, only while the row strobe is high. The address, direction and write data are captured in that clock.
- R10: A refresh is a row-only cycle. `dram_ras_n` stays low for T_REFRAS clocks with no column strobe. Successive refresh rows rise by one, modulo 512 in 1-Mbit mode and modulo 256 in 256-kbit mode.
- R11: A refresh request waits for a running burst and then goes ahead of new requests. Two refresh cycles start no more than REF_PERIOD plus one burst plus T_PRE clocks apart, even when requests arrive back to back.
- R12: Between any two low periods, `dram_ras_n` stays high for at least T_PRE clocks.
- R13: Each column strobe stays low for T_CASL clocks. Between the columns of one burst it stays high for T_CASH clocks, and it is low only while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mbit | input | 1 | 1 selects 1-Mbit geometry, 0 selects 256-kbit |
| req | input | 1 | Transfer request, held until ack |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Word to write |
| ack | output | 1 | Request accepted (one clock) |
| rd_valid | output | 1 | Read word valid (one clock) |
| rd_data | output | 16 | Read word |
| dram_a | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 4 | Nibble driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 4 | Nibble returned by the DRAM |

## Verification
The assertions assume that the requester keeps `req` and its fields stable until `ack`. They also assume that `cfg_mbit` changes only when no request is pending, and that REF_PERIOD is longer than one burst plus precharge, so that a refresh tick never finds an older request still pending. The bench always issues requests through its handshake task and holds the fields until it sees `ack`. It changes the mode only between sweeps, after the last burst has finished, and it uses a refresh period well above the longest wait. The bench's DRAM model returns read data starting from the first clock of each column low phase. This respects the rule that data must be valid when the controller samples it.

// File: rtl/nib_dram_pkg.sv
package nib_dram_pkg;

    localparam int NIB_PER_WORD = 4;
    localparam int NIB_IDX_W    = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_DLY,
        ST_CAS_LO,
        ST_CAS_HI,
        ST_PRECHG,
        ST_REFRESH
    } seq_state_t;

    typedef enum logic [1:0] {
        AMUX_ROW,
        AMUX_COL,
        AMUX_REF
    } amux_t;

    function automatic int max_of5(input int a, input int b, input int c,
                                   input int d, input int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/nib_dram_addr.sv
module nib_dram_addr
    import nib_dram_pkg::*;
#(
    parameter int A_W = 9
) (
    input  logic                 mbit,
    input  amux_t                sel,
    input  logic [2*A_W-3:0]     word_addr,
    input  logic [NIB_IDX_W-1:0] nib,
    input  logic [A_W-1:0]       ref_row,
    output logic [A_W-1:0]       a_out
);
    localparam int WA_W = 2 * A_W - 2;

    logic [A_W-1:0] row_big, col_big, row_small, col_small, ref_addr;

    always_comb begin
        row_big   = word_addr[WA_W-1 -: A_W];
        col_big   = {word_addr[A_W-3:0], nib};
        row_small = {1'b0, word_addr[WA_W-3 -: A_W-1]};
        col_small = {1'b0, word_addr[A_W-4:0], nib};
        ref_addr  = {mbit & ref_row[A_W-1], ref_row[A_W-2:0]};
    end

    always_comb begin
        unique case (sel)
            AMUX_ROW: a_out = mbit ? row_big : row_small;
            AMUX_COL: a_out = mbit ? col_big : col_small;
            AMUX_REF: a_out = ref_addr;
            default:  a_out = '0;
        endcase
    end

endmodule

// File: rtl/nib_dram_refresh.sv
module nib_dram_refresh #(
    parameter int A_W        = 9,
    parameter int REF_PERIOD = 200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           grant,
    output logic           pending,
    output logic [A_W-1:0] row
);
    localparam int TW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;

    logic [TW-1:0] tmr_q;
    logic          tick;

    assign tick = (tmr_q == TW'(REF_PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            pending <= 1'b0;
            row     <= '0;
        end else begin
            tmr_q <= tick ? '0 : tmr_q + 1'b1;
            if (tick)       pending <= 1'b1;
            else if (grant) pending <= 1'b0;
            if (grant)      row <= row + 1'b1;
        end
    end

    // R11: a new tick must never find an older refresh still waiting
    a_r11_no_missed_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (!pending || grant));

    // R10: the row counter moves only when a refresh is granted
    a_r10_row_steps_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> $stable(row));

endmodule

// File: rtl/nib_dram_nibble.sv
module nib_dram_nibble #(
    parameter int NIB_W = 4,
    parameter int NIBS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NIB_W*NIBS-1:0]    wdata,
    input  logic [$clog2(NIBS)-1:0]  sel,
    input  logic                     cap,
    input  logic [NIB_W-1:0]         dq_i,
    output logic [NIB_W-1:0]         dq_o,
    output logic [NIB_W*NIBS-1:0]    rword
);
    localparam int SEL_W = $clog2(NIBS);

    logic [NIB_W*NIBS-1:0] wword_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    wword_q <= '0;
        else if (load) wword_q <= wdata;
    end

    assign dq_o = wword_q[sel*NIB_W +: NIB_W];

    for (genvar g = 0; g < NIBS; g++) begin : g_lane
        logic [NIB_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                         lane_q <= '0;
            else if (cap && sel == SEL_W'(g))   lane_q <= dq_i;
        end
        assign rword[g*NIB_W +: NIB_W] = lane_q;
    end

endmodule

// File: rtl/nib_dram_ctrl.sv
module nib_dram_ctrl
    import nib_dram_pkg::*;
#(
    parameter int A_W        = 9,
    parameter int NIB_W      = 4,
    parameter int T_RCD      = 2,
    parameter int T_CASL     = 2,
    parameter int T_CASH     = 1,
    parameter int T_PRE      = 2,
    parameter int T_REFRAS   = 2,
    parameter int REF_PERIOD = 200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_mbit,
    input  logic                          req,
    input  logic                          req_we,
    input  logic [2*A_W-3:0]              req_addr,
    input  logic [NIB_W*NIB_PER_WORD-1:0] req_wdata,
    output logic                          ack,
    output logic                          rd_valid,
    output logic [NIB_W*NIB_PER_WORD-1:0] rd_data,
    output logic [A_W-1:0]                dram_a,
    output logic                          dram_ras_n,
    output logic                          dram_cas_n,
    output logic                          dram_we_n,
    output logic                          dram_oe_n,
    output logic [NIB_W-1:0]              dram_dq_o,
    output logic                          dram_dq_oe,
    input  logic [NIB_W-1:0]              dram_dq_i
);
    localparam int WA_W  = 2 * A_W - 2;
    localparam int TMAX  = max_of5(T_RCD, T_CASL, T_CASH, T_PRE, T_REFRAS);
    localparam int CNT_W = $clog2(TMAX + 1);
    localparam logic [NIB_IDX_W-1:0] LAST_NIB = NIB_IDX_W'(NIB_PER_WORD - 1);

    seq_state_t           state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic [NIB_IDX_W-1:0] nib_q, nib_d;
    logic                 wr_q;
    logic [WA_W-1:0]      addr_q;
    logic                 rd_valid_q, rd_valid_d;
    logic                 ref_pend, ref_grant;
    logic [A_W-1:0]       ref_row;
    logic                 cap_en, in_burst, cnt_done;
    amux_t                amux;

    assign cnt_done = (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_done ? cnt_q : cnt_q - 1'b1;
        nib_d      = nib_q;
        rd_valid_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pend) begin
                    state_d = ST_REFRESH;
                    cnt_d   = CNT_W'(T_REFRAS - 1);
                end else if (req) begin
                    state_d = ST_ROW_DLY;
                    cnt_d   = CNT_W'(T_RCD - 1);
                    nib_d   = '0;
                end
            end
            ST_ROW_DLY: if (cnt_done) begin
                state_d = ST_CAS_LO;
                cnt_d   = CNT_W'(T_CASL - 1);
            end
            ST_CAS_LO: if (cnt_done) begin
                if (nib_q == LAST_NIB) begin
                    state_d    = ST_PRECHG;
                    cnt_d      = CNT_W'(T_PRE - 1);
                    rd_valid_d = !wr_q;
                end else begin
                    state_d = ST_CAS_HI;
                    cnt_d   = CNT_W'(T_CASH - 1);
                    nib_d   = nib_q + 1'b1;
                end
            end
            ST_CAS_HI: if (cnt_done) begin
                state_d = ST_CAS_LO;
                cnt_d   = CNT_W'(T_CASL - 1);
            end
            ST_PRECHG: if (cnt_done) state_d = ST_IDLE;
            ST_REFRESH: if (cnt_done) begin
                state_d = ST_PRECHG;
                cnt_d   = CNT_W'(T_PRE - 1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            nib_q      <= '0;
            wr_q       <= 1'b0;
            addr_q     <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            nib_q      <= nib_d;
            rd_valid_q <= rd_valid_d;
            if (ack) begin
                wr_q   <= req_we;
                addr_q <= req_addr;
            end
        end
    end

    // outputs
    always_comb begin
        in_burst   = (state_q == ST_ROW_DLY) || (state_q == ST_CAS_LO) ||
                     (state_q == ST_CAS_HI);
        dram_ras_n = !(in_burst || state_q == ST_REFRESH);
        dram_cas_n = (state_q != ST_CAS_LO);
        dram_we_n  = !(in_burst && wr_q);
        dram_oe_n  = !(in_burst && !wr_q);
        dram_dq_oe = in_burst && wr_q;
        ack        = (state_q == ST_IDLE) && req && !ref_pend;
        ref_grant  = (state_q == ST_IDLE) && ref_pend;
        cap_en     = (state_q == ST_CAS_LO) && cnt_done && !wr_q;
        unique case (state_q)
            ST_ROW_DLY: amux = AMUX_ROW;
            ST_REFRESH: amux = AMUX_REF;
            default:    amux = AMUX_COL;
        endcase
    end

    assign rd_valid = rd_valid_q;

    nib_dram_addr #(.A_W(A_W)) addr_i (
        .mbit      (cfg_mbit),
        .sel       (amux),
        .word_addr (addr_q),
        .nib       (nib_q),
        .ref_row   (ref_row),
        .a_out     (dram_a)
    );

    nib_dram_refresh #(.A_W(A_W), .REF_PERIOD(REF_PERIOD)) refresh_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant   (ref_grant),
        .pending (ref_pend),
        .row     (ref_row)
    );

    nib_dram_nibble #(.NIB_W(NIB_W), .NIBS(NIB_PER_WORD)) nibble_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ack),
        .wdata (req_wdata),
        .sel   (nib_q),
        .cap   (cap_en),
        .dq_i  (dram_dq_i),
        .dq_o  (dram_dq_o),
        .rword (rd_data)
    );

    // ---- strobe observers used only by the assertions below ----
    localparam int RW = $clog2(TMAX + 2) + 1;
    logic [RW-1:0] hi_run, lo_run;
    logic [2:0]    cas_falls;
    logic          cas_n_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run    <= RW'(T_PRE);
            lo_run    <= '0;
            cas_falls <= '0;
            cas_n_q   <= 1'b1;
        end else begin
            cas_n_q <= dram_cas_n;
            if (dram_ras_n) begin
                lo_run    <= '0;
                cas_falls <= '0;
                if (hi_run < RW'(T_PRE)) hi_run <= hi_run + 1'b1;
            end else begin
                hi_run <= '0;
                if (lo_run < RW'(TMAX + 1)) lo_run <= lo_run + 1'b1;
                if (cas_n_q && !dram_cas_n) cas_falls <= cas_falls + 1'b1;
            end
        end
    end

    a_r2_four_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (cas_falls == 3'd0 || cas_falls == 3'd4));

    a_r2_rcd_exact: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && cas_falls == 3'd0) |-> (lo_run == RW'(T_RCD)));

    a_r12_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_run >= RW'(T_PRE)));

    a_r13_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    a_r7_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (dram_we_n && !dram_dq_oe));

    a_r6_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !dram_we_n) |-> dram_dq_oe);

    a_r4_a8_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mbit |-> !dram_a[A_W-1]);

    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r9_ack_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (dram_ras_n && req));

    a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

endmodule

// File: tb/nib_dram_ctrl_tb.sv
module nib_dram_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T_RCD      = 2;
    localparam int T_CASL     = 2;
    localparam int T_CASH     = 1;
    localparam int T_PRE      = 2;
    localparam int T_REFRAS   = 2;
    localparam int REF_PERIOD = 60;
    localparam int BURST_LOW  = T_RCD + 4 * T_CASL + 3 * T_CASH;
    localparam int GAP_BOUND  = REF_PERIOD + BURST_LOW + T_PRE + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mbit = 1'b1;
    logic        req = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        ack, rd_valid;
    logic [15:0] rd_data;
    logic [8:0]  dram_a;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [3:0]  dram_dq_o;
    logic [3:0]  dram_dq_i = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int rst_cyc  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nib_dram_ctrl #(
        .T_RCD(T_RCD), .T_CASL(T_CASL), .T_CASH(T_CASH), .T_PRE(T_PRE),
        .T_REFRAS(T_REFRAS), .REF_PERIOD(REF_PERIOD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mbit(cfg_mbit), .req(req),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data), .dram_a(dram_a),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] exp_key(input logic mb, input logic [15:0] wa,
                                            input int n);
        logic [1:0] nn = n[1:0];
        if (mb) return {wa[15:7], wa[6:0], nn};
        return {1'b0, wa[13:6], 1'b0, wa[5:0], nn};
    endfunction

    function automatic logic [15:0] word_of(input logic [15:0] wa);
        return (wa * 16'h9E37) ^ 16'hC3A5;
    endfunction

    // ---- behavioural DRAM model and strobe timing monitor ----
    logic [3:0]  mem [logic [17:0]];
    logic [17:0] burst_key [4];
    logic [17:0] cur_key [4];
    logic [8:0]  cur_row, last_ref_row;
    logic        ras_p = 1'b1, cas_p = 1'b1, fall_mode, last_ref_mode;
    bit          have_ref = 1'b0;
    int ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 0, ncas = 0;
    int fall_cyc = 0, last_ref_cyc = 0, n_ref = 0, bursts_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cfg_mbit && dram_a[8]) chk(1'b0, "R4 A8 high in 256k mode", 1, 0);
            if (!dram_cas_n && dram_ras_n) chk(1'b0, "R13 CAS outside RAS", 1, 0);
            // row strobe
            if (!dram_ras_n && ras_p) begin
                chk(ras_hi >= T_PRE, "R12 precharge", ras_hi, T_PRE);
                cur_row = dram_a; ras_lo = 1; ncas = 0;
                fall_cyc = cyc; fall_mode = cfg_mbit;
            end else if (!dram_ras_n) ras_lo++;
            if (dram_ras_n && !ras_p) begin
                if (ncas == 0) begin
                    chk(ras_lo == T_REFRAS, "R10 refresh low time", ras_lo, T_REFRAS);
                    if (have_ref && last_ref_mode == fall_mode)
                        chk(cur_row == ((last_ref_row + 9'd1) & (fall_mode ? 9'h1FF : 9'h0FF)),
                            "R10 refresh row step", cur_row, last_ref_row + 9'd1);
                    if (have_ref)
                        chk(fall_cyc - last_ref_cyc <= GAP_BOUND, "R11 refresh gap",
                            fall_cyc - last_ref_cyc, GAP_BOUND);
                    have_ref = 1'b1; last_ref_row = cur_row;
                    last_ref_mode = fall_mode; last_ref_cyc = fall_cyc; n_ref++;
                end else begin
                    chk(ncas == 4, "R2 four column strobes", ncas, 4);
                    chk(ras_lo == BURST_LOW, "R13 burst length", ras_lo, BURST_LOW);
                    for (int k = 0; k < 4; k++) burst_key[k] = cur_key[k];
                    bursts_done++;
                end
                ras_hi = 1;
            end else if (dram_ras_n) ras_hi++;
            // column strobe
            if (!dram_cas_n && cas_p) begin
                if (ncas == 0) chk(ras_lo == T_RCD + 1, "R2 row-to-column delay", ras_lo - 1, T_RCD);
                else chk(cas_hi == T_CASH, "R13 column high time", cas_hi, T_CASH);
                if (ncas < 4) cur_key[ncas] = {cur_row, dram_a};
                if (!dram_we_n) begin
                    chk(dram_oe_n && dram_dq_oe, "R6 write strobes", {dram_oe_n, dram_dq_oe}, 2'b11);
                    mem[{cur_row, dram_a}] = dram_dq_o;
                end else begin
                    chk(!dram_oe_n && !dram_dq_oe, "R7 read strobes", {dram_oe_n, dram_dq_oe}, 2'b00);
                    dram_dq_i = mem.exists({cur_row, dram_a}) ? mem[{cur_row, dram_a}] : 4'h0;
                end
                ncas++; cas_lo = 1;
            end else if (!dram_cas_n) cas_lo++;
            if (dram_cas_n && !cas_p) begin
                chk(cas_lo == T_CASL, "R13 column low time", cas_lo, T_CASL);
                cas_hi = 1;
            end else if (dram_cas_n) cas_hi++;
        end
        ras_p = dram_ras_n;
        cas_p = dram_cas_n;
    end

    // ---- transfer task ----
    task automatic xfer(input bit we, input logic [15:0] wa, input logic [15:0] wd,
                        input logic [15:0] exp_rd);
        int base = bursts_done;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = wa; req_wdata = wd;
        #1;
        while (!ack) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        chk(!ack, "R9 ack lasts one clock", ack, 0);
        req = 1'b0;
        if (!we) begin
            while (!rd_valid) begin @(negedge clk); #1; end
            chk(rd_data == exp_rd, "R8 read word", rd_data, exp_rd);
            @(negedge clk); #1;
            chk(!rd_valid, "R8 valid is one pulse", rd_valid, 0);
        end
        wait (bursts_done != base);
        for (int n = 0; n < 4; n++) begin
            chk(burst_key[n] == exp_key(cfg_mbit, wa, n),
                cfg_mbit ? "R3 address split" : "R4 address split",
                burst_key[n], exp_key(cfg_mbit, wa, n));
            if (we) chk(mem[exp_key(cfg_mbit, wa, n)] == wd[4*n +: 4], "R5 nibble order",
                        mem[exp_key(cfg_mbit, wa, n)], wd[4*n +: 4]);
        end
    endtask

    function automatic logic [15:0] sweep_addr(input int i, input logic mb);
        logic [15:0] a;
        if (i < 16) a = 16'h0001 << i;
        else        a = 16'(i * 16'h0A3B + 16'h1111);
        return mb ? a : (a & 16'h3FFF);
    endfunction

    // ---- watchdog ----
    always @(posedge clk) begin
        cyc++;
        if (rst_n) rst_cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!dram_dq_oe && !ack && !rd_valid, "R1 outputs idle in reset",
            {dram_dq_oe, ack, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(dram_ras_n && dram_cas_n && !rd_valid, "R1 idle after reset",
            {dram_ras_n, dram_cas_n, rd_valid}, 3'b110);

        // 1-Mbit sweep: walking ones plus spread addresses, writes then reads
        cfg_mbit = 1'b1;
        for (int i = 0; i < 40; i++) xfer(1'b1, sweep_addr(i, 1'b1), word_of(sweep_addr(i, 1'b1)), '0);
        for (int i = 0; i < 40; i++) xfer(1'b0, sweep_addr(i, 1'b1), '0, word_of(sweep_addr(i, 1'b1)));

        // 256-kbit sweep: odd entries written with the ignored top bits set
        repeat (4) @(negedge clk);
        cfg_mbit = 1'b0;
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a = sweep_addr(i, 1'b0);
            xfer(1'b1, (i % 2 == 1) ? (a | 16'hC000) : a, word_of(a), '0);
        end
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a = sweep_addr(i, 1'b0);
            // R4: top bits ignored, so the aliased write reads back here
            xfer(1'b0, a, '0, word_of(a));
        end

        // overwrite and read back in 1-Mbit mode with complemented data
        repeat (4) @(negedge clk);
        cfg_mbit = 1'b1;
        for (int i = 0; i < 8; i++) xfer(1'b1, sweep_addr(i + 20, 1'b1), ~word_of(sweep_addr(i + 20, 1'b1)), '0);
        for (int i = 0; i < 8; i++) xfer(1'b0, sweep_addr(i + 20, 1'b1), '0, ~word_of(sweep_addr(i + 20, 1'b1)));

        repeat (3 * REF_PERIOD) @(negedge clk);
        chk(n_ref >= rst_cyc / REF_PERIOD - 2, "R11 refresh count", n_ref, rst_cyc / REF_PERIOD - 2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule